// File: doc/BRIEF.md
# Instruction Fetch Unit with Compressed-Instruction Splitting

This block turns a virtual fetch address into one instruction. For a 4-byte-aligned fetch it first looks in a small direct-mapped store of instruction words. On a miss it asks an external translator for the physical address, reads one 32-bit word from memory, returns the word and writes it into the store. When 16-bit compressed instructions are enabled, a fetch may also start two bytes into a word. The unit then translates that address and reads a single halfword. If that halfword is a full-length encoding, it translates the next halfword address on its own, reads that halfword and joins the two. Fetches that start on a halfword are never placed in the store.

Translation and memory sit outside the block. Each is reached through a request/acknowledge pair. A fetch that is not aligned well enough ends in a one-cycle misaligned-fault pulse. A translation that reports a fault ends in a one-cycle translation-fault pulse. A flush input drops every entry in the store at once.

Top module: `ifetch_split`

## Requirements
- R1: While reset is asserted and just after it, `out_valid`, `out_misalign`, `out_xfault`, `tr_req` and `mem_req` are all low.
- R2: On a miss, an aligned fetch (`pc[1:0]==0`) makes one translation of `pc` and one 32-bit read (`mem_half`=0) at the returned physical address. The word that is read appears on `out_instr` with `out_valid`.
- R3: A repeated aligned fetch of an address already in the store sets `out_valid` in the cycle after the request. It returns the stored word and raises neither port request.
- R4: The store holds `ENTRIES` entries indexed by `pc[IW+1:2]`, and the full address is compared. A fetch to another address with the same index replaces the entry, so the first address misses again afterwards.
- R5: With `cmp_en`=1 and `pc[1:0]==2'b10`, the block translates `pc` and reads one halfword (`mem_half`=1, taken from `mem_rdata[15:0]`). If bits [1:0] of that halfword are not `2'b11`, the result is `{16'h0, halfword}` after exactly one translation and one read.
- R6: If that first halfword has bits [1:0] equal to `2'b11`, the block translates `pc+2` separately and reads a second halfword. The result is `{second, first}`.
- R7: A fetch that starts on a halfword never fills the store. Repeating it goes out to the ports again.
- R8: A fetch with `pc[0]=1`, or with `pc[1]=1` while `cmp_en`=0, raises `out_misalign` in the cycle after the request. It makes no translation or memory request.
- R9: A translation answered with `tr_fault`=1, for either the first or the second halfword, ends the fetch with an `out_xfault` pulse. `out_valid` stays low and no memory read follows that translation.
- R10: A `flush` pulse empties the whole store, so a later aligned fetch misses. A fetch already in flight when the flush arrives does not fill the store.
- R11: `tr_req` and `tr_vaddr` hold steady until `tr_ack`. `mem_req`, `mem_addr` and `mem_half` hold steady until `mem_ack`. The two requests are never high together.
- R12: Each fetch produces exactly one of `out_valid`, `out_misalign` or `out_xfault`, high for a single cycle.
- R13: A request that arrives while a fetch is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every store entry |
| req | input | 1 | Fetch request strobe |
| pc | input | AW | Virtual fetch address |
| cmp_en | input | 1 | Compressed instructions allowed |
| tr_req | output | 1 | Translation request |
| tr_vaddr | output | AW | Virtual address to translate |
| tr_ack | input | 1 | Translation done |
| tr_fault | input | 1 | Translation refused |
| tr_paddr | input | AW | Translated physical address |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Physical read address |
| mem_half | output | 1 | 1 = halfword read, 0 = word read |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data; halfword reads use bits [15:0] |
| out_valid | output | 1 | Instruction valid pulse |
| out_instr | output | 32 | Fetched instruction |
| out_misalign | output | 1 | Misaligned-fetch fault pulse |
| out_xfault | output | 1 | Translation fault pulse |

## Verification
The hold properties assume that the translator and memory raise an acknowledge only while the matching request is high, and for one cycle per request. The bench responders follow that rule: each answers one cycle after it sees a request and then drops its acknowledge. The word-read property assumes that translation keeps the page offset. The bench translator therefore flips only bit 16 of the address. The bench also drops `req` after one cycle, except in the deliberate busy-request test.

// File: rtl/ifetch_split.sv
module ifetch_split #(
  parameter int AW      = 32,
  parameter int ENTRIES = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          req,
  input  logic [AW-1:0] pc,
  input  logic          cmp_en,
  output logic          tr_req,
  output logic [AW-1:0] tr_vaddr,
  input  logic          tr_ack,
  input  logic          tr_fault,
  input  logic [AW-1:0] tr_paddr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_half,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          out_valid,
  output logic [31:0]   out_instr,
  output logic          out_misalign,
  output logic          out_xfault
);
  localparam int IW = $clog2(ENTRIES);

  typedef enum logic [1:0] {S_IDLE, S_TR, S_MEM} st_t;

  st_t                 state;
  logic [AW-1:0]       pc_q, pa_q;
  logic                half_q, hi_q, nofill_q;
  logic [15:0]         lo_q;
  logic [ENTRIES-1:0]  vld;
  logic [AW-1:0]       tag_mem [ENTRIES];
  logic [31:0]         dat_mem [ENTRIES];

  logic [IW-1:0] idx, fidx;
  logic          aligned, half_start, hit, fill_en;

  assign idx        = pc[IW+1:2];
  assign fidx       = pc_q[IW+1:2];
  assign aligned    = (pc[1:0] == 2'b00);
  assign half_start = (pc[1:0] == 2'b10) && cmp_en;
  assign hit        = aligned && vld[idx] && (tag_mem[idx] == pc) && !flush;
  assign fill_en    = (state == S_MEM) && mem_ack && !half_q && !flush && !nofill_q;

  assign tr_req   = (state == S_TR);
  assign tr_vaddr = hi_q ? pc_q + AW'(2) : pc_q;
  assign mem_req  = (state == S_MEM);
  assign mem_addr = pa_q;
  assign mem_half = half_q;

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_mem[fidx] <= pc_q;
      dat_mem[fidx] <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      pc_q         <= '0;
      pa_q         <= '0;
      half_q       <= 1'b0;
      hi_q         <= 1'b0;
      nofill_q     <= 1'b0;
      lo_q         <= '0;
      vld          <= '0;
      out_valid    <= 1'b0;
      out_instr    <= '0;
      out_misalign <= 1'b0;
      out_xfault   <= 1'b0;
    end else begin
      out_valid    <= 1'b0;
      out_misalign <= 1'b0;
      out_xfault   <= 1'b0;
      if (flush) vld <= '0;
      if (fill_en) vld[fidx] <= 1'b1;
      case (state)
        S_IDLE: if (req) begin
          pc_q     <= pc;
          hi_q     <= 1'b0;
          half_q   <= half_start;
          nofill_q <= 1'b0;
          if (hit) begin
            out_valid <= 1'b1;
            out_instr <= dat_mem[idx];
          end else if (aligned || half_start) begin
            state <= S_TR;
          end else begin
            out_misalign <= 1'b1;
          end
        end
        S_TR: begin
          if (flush) nofill_q <= 1'b1;
          if (tr_ack) begin
            if (tr_fault) begin
              out_xfault <= 1'b1;
              state      <= S_IDLE;
            end else begin
              pa_q  <= tr_paddr;
              state <= S_MEM;
            end
          end
        end
        S_MEM: begin
          if (flush) nofill_q <= 1'b1;
          if (mem_ack) begin
            if (half_q && !hi_q) begin
              lo_q <= mem_rdata[15:0];
              if (mem_rdata[1:0] == 2'b11) begin
                hi_q  <= 1'b1;
                state <= S_TR;
              end else begin
                out_valid <= 1'b1;
                out_instr <= {16'h0, mem_rdata[15:0]};
                state     <= S_IDLE;
              end
            end else if (half_q) begin
              out_valid <= 1'b1;
              out_instr <= {mem_rdata[15:0], lo_q};
              state     <= S_IDLE;
            end else begin
              out_valid <= 1'b1;
              out_instr <= mem_rdata;
              state     <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module ifetch_split_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          tr_req,
  input logic [AW-1:0] tr_vaddr,
  input logic          tr_ack,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_half,
  input logic          mem_ack,
  input logic          out_valid,
  input logic          out_misalign,
  input logic          out_xfault
);
  // R12
  outs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, out_misalign, out_xfault}));

  // R11
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tr_req && mem_req));

  // R11
  tr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tr_req && !tr_ack |=> tr_req && $stable(tr_vaddr));

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_half));

  // R8
  misal_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_misalign) |-> $past(req));

  // R2
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_half |-> mem_addr[1:0] == 2'b00);
endmodule

bind ifetch_split ifetch_split_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req),
  .tr_req(tr_req), .tr_vaddr(tr_vaddr), .tr_ack(tr_ack),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_half(mem_half), .mem_ack(mem_ack),
  .out_valid(out_valid), .out_misalign(out_misalign), .out_xfault(out_xfault)
);

// File: tb/ifetch_split_tb.sv
module ifetch_split_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req = 1'b0;
  logic [31:0] pc = '0;
  logic        cmp_en = 1'b0;
  logic        tr_req, tr_ack = 1'b0, tr_fault = 1'b0;
  logic [31:0] tr_vaddr, tr_paddr = '0;
  logic        mem_req, mem_half, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        out_valid, out_misalign, out_xfault;
  logic [31:0] out_instr;

  int checks = 0, fails = 0, tr_cnt = 0, mem_cnt = 0, cyc = 0;
  logic [31:0] va0 = '0, va1 = '0;

  ifetch_split u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req(req), .pc(pc), .cmp_en(cmp_en),
    .tr_req(tr_req), .tr_vaddr(tr_vaddr), .tr_ack(tr_ack), .tr_fault(tr_fault),
    .tr_paddr(tr_paddr), .mem_req(mem_req), .mem_addr(mem_addr), .mem_half(mem_half),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .out_valid(out_valid),
    .out_instr(out_instr), .out_misalign(out_misalign), .out_xfault(out_xfault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] xl(input logic [31:0] v);
    return v ^ 32'h0001_0000;
  endfunction
  function automatic logic [15:0] hw(input logic [31:0] pa);
    return {pa[17:4], pa[3] ? 2'b11 : 2'b01};
  endfunction
  function automatic logic [31:0] exp_instr(input logic [31:0] a);
    logic [15:0] lo;
    if (a[1:0] == 2'b00) return {hw(xl(a) + 32'd2), hw(xl(a))};
    lo = hw(xl(a));
    if (lo[1:0] != 2'b11) return {16'h0, lo};
    return {hw(xl(a + 32'd2)), lo};
  endfunction

  always @(negedge clk) begin
    if (tr_req && !tr_ack) begin
      tr_ack   <= 1'b1;
      tr_paddr <= xl(tr_vaddr);
      tr_fault <= (tr_vaddr[31:12] == 20'hDEAD0);
      va1 <= va0;
      va0 <= tr_vaddr;
    end else tr_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem_half ? {16'h0, hw(mem_addr)} : {hw(mem_addr + 32'd2), hw(mem_addr)};
    end else mem_ack <= 1'b0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tr_req && tr_ack) tr_cnt <= tr_cnt + 1;
    if (mem_req && mem_ack) mem_cnt <= mem_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_out(output int kind, output logic [31:0] ins, output int lat);
    lat = 1;
    while (!(out_valid || out_misalign || out_xfault) && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    kind = out_valid ? 0 : out_misalign ? 1 : out_xfault ? 2 : 3;
    ins  = out_instr;
    @(negedge clk);
    chk(!(out_valid || out_misalign || out_xfault), "R12 single pulse",
        {29'h0, out_valid, out_misalign, out_xfault}, 32'h0);
  endtask

  task automatic fetch(input logic [31:0] a, input logic c,
                       output int kind, output logic [31:0] ins, output int lat,
                       output int dtr, output int dmem);
    int t0, m0;
    t0 = tr_cnt; m0 = mem_cnt;
    req = 1'b1; pc = a; cmp_en = c;
    @(negedge clk);
    req = 1'b0;
    wait_out(kind, ins, lat);
    dtr = tr_cnt - t0; dmem = mem_cnt - m0;
  endtask

  typedef struct packed {
    logic [31:0] a;
    logic        c;
    logic [1:0]  kind;
    logic [1:0]  ntr;
    logic [1:0]  nmem;
    logic [15:0] tag;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{32'h0000_1000, 1'b0, 2'd0, 2'd1, 2'd1, "R2"},
    '{32'h0000_1000, 1'b0, 2'd0, 2'd0, 2'd0, "R3"},
    '{32'h0000_1400, 1'b0, 2'd0, 2'd1, 2'd1, "R4"},
    '{32'h0000_1000, 1'b0, 2'd0, 2'd1, 2'd1, "R4"},
    '{32'h0000_2002, 1'b1, 2'd0, 2'd1, 2'd1, "R5"},
    '{32'h0000_200A, 1'b1, 2'd0, 2'd2, 2'd2, "R6"},
    '{32'h0000_2002, 1'b1, 2'd0, 2'd1, 2'd1, "R7"},
    '{32'h0000_2001, 1'b1, 2'd1, 2'd0, 2'd0, "R8"},
    '{32'h0000_2006, 1'b0, 2'd1, 2'd0, 2'd0, "R8"},
    '{32'h DEAD_0000, 1'b0, 2'd2, 2'd1, 2'd0, "R9"},
    '{32'h DEAC_FFFE, 1'b1, 2'd2, 2'd2, 2'd1, "R9"},
    '{32'h0000_2004, 1'b1, 2'd0, 2'd1, 2'd1, "R2"},
    '{32'h0000_2004, 1'b1, 2'd0, 2'd0, 2'd0, "R3"}
  };

  initial begin
    int k, lat, dtr, dmem, t0;
    logic [31:0] ins;

    repeat (3) @(negedge clk);
    // R1
    chk(!(out_valid || out_misalign || out_xfault || tr_req || mem_req), "R1 reset outputs",
        {27'h0, out_valid, out_misalign, out_xfault, tr_req, mem_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!(out_valid || out_misalign || out_xfault || tr_req || mem_req), "R1 after reset",
        {27'h0, out_valid, out_misalign, out_xfault, tr_req, mem_req}, 32'h0);

    foreach (VEC[i]) begin
      fetch(VEC[i].a, VEC[i].c, k, ins, lat, dtr, dmem);
      chk(k == int'(VEC[i].kind), $sformatf("%s kind pc=%h", VEC[i].tag, VEC[i].a), k, VEC[i].kind);
      if (VEC[i].kind == 2'd0)
        chk(ins == exp_instr(VEC[i].a), $sformatf("%s instr pc=%h", VEC[i].tag, VEC[i].a),
            ins, exp_instr(VEC[i].a));
      chk(dtr == int'(VEC[i].ntr), $sformatf("%s translations pc=%h", VEC[i].tag, VEC[i].a), dtr, VEC[i].ntr);
      chk(dmem == int'(VEC[i].nmem), $sformatf("%s reads pc=%h", VEC[i].tag, VEC[i].a), dmem, VEC[i].nmem);
      if (VEC[i].ntr == 2'd0)
        chk(lat == 1, $sformatf("%s latency pc=%h", VEC[i].tag, VEC[i].a), lat, 1);
    end

    // R11 split fetch translates pc then pc+2
    fetch(32'h0000_300A, 1'b1, k, ins, lat, dtr, dmem);
    chk(va1 == 32'h0000_300A, "R11 first vaddr", va1, 32'h0000_300A);
    chk(va0 == 32'h0000_300C, "R11 second vaddr", va0, 32'h0000_300C);
    chk(ins == exp_instr(32'h0000_300A), "R6 second split", ins, exp_instr(32'h0000_300A));

    // R10 flush empties store
    fetch(32'h0000_1000, 1'b0, k, ins, lat, dtr, dmem);
    chk(dtr == 0 && lat == 1, "R10 pre-flush hit", dtr, 0);
    flush = 1'b1; @(negedge clk); flush = 1'b0;
    fetch(32'h0000_1000, 1'b0, k, ins, lat, dtr, dmem);
    chk(dtr == 1, "R10 miss after flush", dtr, 1);
    chk(ins == exp_instr(32'h0000_1000), "R10 data after flush", ins, exp_instr(32'h0000_1000));

    // R10 flush during a miss suppresses fill
    t0 = tr_cnt;
    req = 1'b1; pc = 32'h0000_4000; cmp_en = 1'b0;
    @(negedge clk);
    req = 1'b0; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    wait_out(k, ins, lat);
    chk(k == 0 && ins == exp_instr(32'h0000_4000), "R10 in-flight result", ins, exp_instr(32'h0000_4000));
    fetch(32'h0000_4000, 1'b0, k, ins, lat, dtr, dmem);
    chk(dtr == 1, "R10 in-flight not filled", dtr, 1);

    // R13 request while busy is ignored
    t0 = tr_cnt;
    req = 1'b1; pc = 32'h0000_5000; cmp_en = 1'b0;
    @(negedge clk);
    pc = 32'h0000_5100;
    @(negedge clk);
    req = 1'b0;
    wait_out(k, ins, lat);
    chk(k == 0 && ins == exp_instr(32'h0000_5000), "R13 first request served", ins, exp_instr(32'h0000_5000));
    repeat (4) @(negedge clk);
    chk(tr_cnt - t0 == 1, "R13 busy request dropped", tr_cnt - t0, 1);
    chk(!(out_valid || out_misalign || out_xfault), "R13 no extra result",
        {29'h0, out_valid, out_misalign, out_xfault}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule